// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable stand-in for a small serial EEPROM that talks over a chip-select, serial-clock, data-in and data-out link. A host raises chip select and clocks in a frame made of a leading one, a two-bit command code and an address. A program frame also carries a data word. The device samples data in on the rising serial-clock edge. The serial pins are brought into the system-clock domain through a synchroniser, and all decoding runs on the system clock.

Program and erase are self-timed. The cycle is launched by the falling edge of chip select that follows a complete frame, and a counter of system-clock cycles times it, so it needs no serial-clock activity. While the cycle runs, a host that selects the device sees busy on data out. Once the cycle ends it sees ready. A read command is also provided, so that stored contents can be inspected over the same pins.

Data out is modelled as a value plus an output enable, so a pad or bench can build the tri-state driver from them.

Top module: `uwire_eeprom`

## Requirements
- R1: A frame begins at the first serial-clock rising edge with data in high while selected, and leading zeros are skipped. The next two bits form the command code, first bit in the high position: 01 = program, 11 = erase, 10 = read. Code 00 makes the rest of the frame have no effect, and no cycle starts.
- R2: A program frame carries ADDR_W address bits and then DATA_W data bits, both most significant first. After the cycle, the word at that address equals the data.
- R3: A program overwrites the old word fully, without a prior erase. Writing 5A over A5 yields 5A.
- R4: The cycle starts on the falling edge of chip select after a complete program or erase frame. It lasts PROG_CYCLES system clocks, with no serial-clock edges required.
- R5: With chip select high during a cycle, data out is driven low (busy). After the cycle it is driven high (ready). After the first deselect that follows ready, selecting the device again leaves data out undriven.
- R6: An erase frame sets every bit of the addressed word to one.
- R7: For a read, the serial-clock edge that takes the last address bit drives data out low as a dummy bit. Each of the next DATA_W rising edges then presents one stored bit, most significant first.
- R8: Data out is undriven whenever chip select has been low for more than the synchroniser latency.
- R9: A program or erase frame cut short by chip select falling early starts no cycle and changes no word.
- R10: A frame clocked in while a cycle runs is ignored. Memory keeps its value and no second cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; times the self-timed cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock; data in is sampled on its rising edge |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value (status or read data) |
| do_oe | output | 1 | Output enable for data out; low means high impedance |

## Verification
Some properties are checked on every cycle by assertions. A running cycle holds busy until its count expires and then releases it after exactly one more edge. No cycle can start while one is already running. The armed state is reachable only from the last address or data bit. Whenever the device drives status during a cycle, data out is low. Other behaviours only show up in the bench scenarios: bit order, leading-zero skipping, the overwrite and erase results, the read dummy bit, and the length of the busy window. The same holds for the standby after ready, and for truncated, no-op and busy-time frames leaving memory untouched.

// File: rtl/uwe_pkg.sv
`timescale 1ns/1ps
package uwe_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } uwe_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DATA,
    ST_RDOUT,
    ST_ARMED,
    ST_SKIP
  } uwe_st_e;
endpackage

// File: rtl/uwe_sync.sv
`timescale 1ns/1ps
module uwe_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // STAGES must be at least 2
  logic [STAGES-1:0][W-1:0] pipe;
  logic [STAGES-1:0][W-1:0] pipe_n;

  always_comb begin
    pipe_n = {pipe[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= pipe_n;
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/uwe_array.sv
`timescale 1ns/1ps
module uwe_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // storage array: no reset, written only on the cycle's last edge
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

  assert_wr_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$isunknown({wr_addr, wr_data}));
endmodule

// File: rtl/uwe_timer.sv
`timescale 1ns/1ps
module uwe_timer #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              cs_fall,
  input  logic              start_seen,
  output logic              busy,
  output logic              stat_pend,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES - 1);

  logic [CW-1:0]     cnt, cnt_n;
  logic              busy_n, stat_n;
  logic [ADDR_W-1:0] lat_addr, lat_addr_n;
  logic [DATA_W-1:0] lat_data, lat_data_n;

  always_comb begin
    busy_n     = busy;
    cnt_n      = cnt;
    stat_n     = stat_pend;
    lat_addr_n = lat_addr;
    lat_data_n = lat_data;
    if (start) begin
      busy_n     = 1'b1;
      cnt_n      = LOAD;
      stat_n     = 1'b1;
      lat_addr_n = addr;
      lat_data_n = erase ? '1 : data;
    end else if (busy) begin
      if (cnt == '0) busy_n = 1'b0;
      else           cnt_n  = cnt - 1'b1;
    end else if (cs_fall || start_seen) begin
      stat_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      stat_pend <= 1'b0;
      lat_addr  <= '0;
      lat_data  <= '0;
    end else begin
      busy      <= busy_n;
      cnt       <= cnt_n;
      stat_pend <= stat_n;
      lat_addr  <= lat_addr_n;
      lat_data  <= lat_data_n;
    end
  end

  assign wr_en   = busy && (cnt == '0);
  assign wr_addr = lat_addr;
  assign wr_data = lat_data;

  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> busy);
  assert_busy_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == '0) |=> !busy);
  assert_no_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/uwe_cmd.sv
`timescale 1ns/1ps
module uwe_cmd import uwe_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sk_s,
  input  logic              di_s,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              start,
  output logic              cmd_erase,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cs_fall,
  output logic              start_seen,
  output logic              rd_active,
  output logic              rd_bit
);
  localparam int MAXW  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CNT_W = $clog2(MAXW + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  uwe_st_e           st, st_n;
  uwe_op_e           op, op_n, full_op;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic [ADDR_W-1:0] addr, addr_n;
  logic [DATA_W-1:0] data, data_n;
  logic [DATA_W-1:0] rsh, rsh_n;
  logic              rbit, rbit_n;
  logic              sk_q, cs_q;
  logic              sk_rise;

  assign sk_rise = sk_s && !sk_q;
  assign cs_fall = cs_q && !cs_s;
  assign full_op = uwe_op_e'({op[0], di_s});
  assign rd_addr = {addr[ADDR_W-2:0], di_s};

  always_comb begin
    st_n       = st;
    op_n       = op;
    cnt_n      = cnt;
    addr_n     = addr;
    data_n     = data;
    rsh_n      = rsh;
    rbit_n     = rbit;
    start_seen = 1'b0;
    if (!cs_s) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
    end else if (sk_rise && !busy) begin
      case (st)
        ST_IDLE: begin
          if (di_s) begin
            st_n       = ST_OPC;
            cnt_n      = '0;
            start_seen = 1'b1;
          end
        end
        ST_OPC: begin
          op_n = full_op;
          if (cnt == '0) begin
            cnt_n = CNT_W'(1);
          end else begin
            cnt_n = '0;
            st_n  = (full_op == OP_NONE) ? ST_SKIP : ST_ADDR;
          end
        end
        ST_ADDR: begin
          addr_n = rd_addr;
          if (cnt == ADDR_LAST) begin
            cnt_n = '0;
            case (op)
              OP_READ: begin
                st_n   = ST_RDOUT;
                rsh_n  = rd_word;
                rbit_n = 1'b0;
              end
              OP_WRITE: st_n = ST_DATA;
              default:  st_n = ST_ARMED;
            endcase
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        ST_DATA: begin
          data_n = {data[DATA_W-2:0], di_s};
          if (cnt == DATA_LAST) begin
            cnt_n = '0;
            st_n  = ST_ARMED;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        ST_RDOUT: begin
          rbit_n = rsh[DATA_W-1];
          rsh_n  = {rsh[DATA_W-2:0], 1'b1};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      op   <= OP_NONE;
      cnt  <= '0;
      addr <= '0;
      data <= '0;
      rsh  <= '0;
      rbit <= 1'b0;
      sk_q <= 1'b0;
      cs_q <= 1'b0;
    end else begin
      st   <= st_n;
      op   <= op_n;
      cnt  <= cnt_n;
      addr <= addr_n;
      data <= data_n;
      rsh  <= rsh_n;
      rbit <= rbit_n;
      sk_q <= sk_s;
      cs_q <= cs_s;
    end
  end

  assign start     = cs_fall && (st == ST_ARMED);
  assign cmd_erase = (op == OP_ERASE);
  assign cmd_addr  = addr;
  assign cmd_data  = data;
  assign rd_active = (st == ST_RDOUT);
  assign rd_bit    = rbit;

  assert_armed_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ARMED && $past(st) != ST_ARMED) |->
      ($past(st) == ST_DATA || $past(st) == ST_ADDR));
  assert_idle_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> st == ST_IDLE);
endmodule

// File: rtl/uwire_eeprom.sv
`timescale 1ns/1ps
module uwire_eeprom #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);
  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic              cs_s, sk_s, di_s;
  logic              busy, stat_pend, start, cmd_erase, cs_fall, start_seen;
  logic              rd_active, rd_bit, wr_en;
  logic [ADDR_W-1:0] rd_addr, cmd_addr, wr_addr;
  logic [DATA_W-1:0] rd_word, cmd_data, wr_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  uwe_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d({cs, sk, di}), .q({cs_s, sk_s, di_s})
  );

  uwe_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst_n(rst_int_n), .cs_s(cs_s), .sk_s(sk_s), .di_s(di_s),
    .busy(busy), .rd_word(rd_word), .rd_addr(rd_addr), .start(start),
    .cmd_erase(cmd_erase), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cs_fall(cs_fall), .start_seen(start_seen), .rd_active(rd_active),
    .rd_bit(rd_bit)
  );

  uwe_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .start(start), .erase(cmd_erase),
    .addr(cmd_addr), .data(cmd_data), .cs_fall(cs_fall),
    .start_seen(start_seen), .busy(busy), .stat_pend(stat_pend),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  uwe_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_word)
  );

  assign do_oe = cs_s && (stat_pend || rd_active);
  assign do_o  = rd_active ? rd_bit : !busy;

  assert_busy_low_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (do_oe && busy) |-> !do_o);
endmodule

// File: tb/uwire_eeprom_test.sv
`timescale 1ns/1ps
module uwire_eeprom_test;
  localparam int PC = 300;

  logic clk = 1'b0;
  logic rst_n, cs, sk, di;
  logic do_o, do_oe;
  int   checks = 0;
  int   fails  = 0;
  bit   finished = 1'b0;
  bit   mon_on = 1'b0;
  int   low_cnt = 0;
  logic [7:0] model [256];

  always #10 clk = ~clk;

  uwire_eeprom #(.PROG_CYCLES(PC)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .do_o(do_o), .do_oe(do_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    di = b; wait_n(3);
    sk = 1'b1; wait_n(6);
    sk = 1'b0; wait_n(3);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic sel();
    cs = 1'b1; wait_n(6);
  endtask

  task automatic desel();
    cs = 1'b0; di = 1'b0; wait_n(6);
  endtask

  // waits for ready, then confirms standby (R5)
  task automatic wait_ready(input bit time_it);
    int n = 0;
    sel();
    if (time_it) check(do_oe && !do_o, "R5 busy", {do_oe, do_o}, 2'b10);
    for (int i = 0; i < 700; i++) begin
      wait_n(1); n++;
      if (do_oe && do_o) break;
    end
    check(do_oe && do_o, "R5 ready", {do_oe, do_o}, 2'b11);
    if (time_it) check(n >= 285 && n <= 295, "R4 cycle length", n, 291);
    desel();
    sel();
    check(!do_oe, "R5 standby", do_oe, 0);
    desel();
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input bit wait_it);
    sel();
    send_bits(3'b101, 3);
    send_bits(a, 8);
    send_bits(d, 8);
    desel();
    model[a] = d;
    if (wait_it) wait_ready(1'b1);
  endtask

  task automatic do_erase(input logic [7:0] a);
    sel();
    send_bits(3'b111, 3);
    send_bits(a, 8);
    desel();
    model[a] = 8'hFF;
    wait_ready(1'b0);
  endtask

  task automatic do_read(input logic [7:0] a, input string req);
    logic [7:0] got = '0;
    sel();
    send_bits(3'b110, 3);
    send_bits(a, 8);
    check(do_oe && !do_o, "R7 dummy bit", {do_oe, do_o}, 2'b10);
    for (int i = 0; i < 8; i++) begin
      send_bit(1'b0);
      got = {got[6:0], do_o};
    end
    desel();
    check(got == model[a], req, got, model[a]);
  endtask

  // R8: data out released whenever chip select has been low for a while
  always @(negedge clk) begin
    if (mon_on) begin
      if (cs) low_cnt = 0;
      else    low_cnt++;
      if (low_cnt >= 4) check(!do_oe, "R8 released", do_oe, 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; cs = 1'b0; sk = 1'b0; di = 1'b0;
    wait_n(5);
    check(!do_oe, "R8 reset", do_oe, 0);
    rst_n = 1'b1;
    wait_n(5);
    mon_on = 1'b1;

    // R1 leading zeros then program; R2 bit order; R4/R5 timing
    sel();
    send_bits(2'b00, 2);
    send_bits(3'b101, 3);
    send_bits(8'h3C, 8);
    send_bits(8'hA5, 8);
    desel();
    model[8'h3C] = 8'hA5;
    wait_ready(1'b1);
    do_read(8'h3C, "R2 program readback");

    // R3 overwrite without erase
    do_write(8'h3C, 8'h5A, 1'b1);
    do_read(8'h3C, "R3 overwrite");

    // R6 erase
    do_erase(8'h3C);
    do_read(8'h3C, "R6 erased to ones");

    // boundary addresses, R7 read order
    do_write(8'h81, 8'h0F, 1'b0);
    wait_ready(1'b0);
    do_read(8'h81, "R7 read order");
    do_write(8'hFF, 8'h00, 1'b0);
    wait_ready(1'b0);
    do_read(8'hFF, "R2 top address");
    do_write(8'h00, 8'hC3, 1'b0);
    wait_ready(1'b0);
    do_read(8'h00, "R2 bottom address");

    // R9 truncated frames
    sel();
    send_bits(3'b101, 3);
    send_bits(4'h8, 4);
    desel();
    sel();
    check(!do_oe, "R9 no cycle after short address", do_oe, 0);
    desel();
    sel();
    send_bits(3'b101, 3);
    send_bits(8'h81, 8);
    send_bits(7'h3B, 7);
    desel();
    sel();
    check(!do_oe, "R9 no cycle after short data", do_oe, 0);
    desel();
    do_read(8'h81, "R9 word unchanged");

    // R1 command code 00
    sel();
    send_bits(3'b100, 3);
    send_bits(8'h81, 8);
    send_bits(8'h66, 8);
    desel();
    sel();
    check(!do_oe, "R1 code 00 starts no cycle", do_oe, 0);
    desel();
    do_read(8'h81, "R1 code 00 no effect");

    // R10 frame during busy
    do_write(8'h10, 8'h33, 1'b0);
    sel();
    check(do_oe && !do_o, "R10 busy seen", {do_oe, do_o}, 2'b10);
    send_bits(3'b101, 3);
    send_bits(8'h81, 8);
    send_bits(8'h99, 8);
    desel();
    wait_ready(1'b0);
    sel();
    check(!do_oe, "R10 no second cycle", do_oe, 0);
    desel();
    do_read(8'h81, "R10 ignored frame");
    do_read(8'h10, "R10 running cycle completed");

    finished = 1'b1;
    report();
  end
endmodule